// File: doc/BRIEF.md
# Presettable Binary Down Counter

This block is a down counter with a parallel preset, meant for divide-by-N clocks, programmable delays and interval timers. On each rising clock edge the count drops by one while counting is enabled. When the count passes zero it wraps to the all-ones value, so a free-running stage has a cycle of 2^WIDTH clocks. A parallel data bus (`jam`) can be loaded in two ways. The synchronous load takes effect at the next clock edge. The asynchronous load takes effect at once. A separate clear forces the count to all ones at any time.

All controls and the terminal output are active-low. `term_n` is a combinational decode: it is low when the count is zero and counting is enabled. Stages can be chained on a common clock by feeding one stage's `term_n` into the next stage's `cnt_en_n`. Feeding `term_n` back into `sload_n` with N on `jam` divides the clock by N+1. The default width is 8.

Top module: `preset_down_counter`

## Requirements
- R1: While `clr_max_n` is low, `count` is all ones (0xFF at the default width). This takes effect without waiting for a clock edge and overrides every other input.
- R2: While `aload_n` is low and `clr_max_n` is high, `count` equals `jam` and follows it without a clock. After release, the count keeps the `jam` value seen at the last rising edge of the load, or at the load's falling edge if no rising edge occurred.
- R3: When `sload_n` is low, the rising edge loads `jam` into the count, whatever the state of `cnt_en_n`.
- R4: With both loads and the clear high and `cnt_en_n` low, every rising edge lowers the count by exactly one.
- R5: With both loads and the clear high and `cnt_en_n` high, the count holds its value across clock edges.
- R6: `term_n` is low exactly when the count is zero and `cnt_en_n` is low, and it follows `cnt_en_n` without a clock. While counting, it stays low for one clock period only.
- R7: Counting down from zero yields all ones, so a free-running stage repeats every 2^WIDTH clocks.
- R8: With `term_n` fed to `sload_n` and N on `jam`, `term_n` pulses low once every N+1 clocks.
- R9: `jam[WIDTH-1]` is the most significant bit: loading 0x80 and counting once gives 0x7F.
- R10: Precedence from highest to lowest is the clear, then the asynchronous load, then the synchronous load, then counting or holding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter acts on the rising edge |
| clr_max_n | input | 1 | Asynchronous clear to all ones, active-low |
| aload_n | input | 1 | Asynchronous parallel load of `jam`, active-low |
| sload_n | input | 1 | Synchronous parallel load of `jam`, active-low |
| cnt_en_n | input | 1 | Count and terminal enable, active-low |
| jam | input | WIDTH | Parallel preset data, bit WIDTH-1 most significant |
| count | output | WIDTH | Current count value |
| term_n | output | 1 | Zero-count flag gated by the enable, active-low |

## Verification
The hardest cases are the ones that happen between clock edges. These are the clear and the asynchronous load acting with no edge at all, and `term_n` reacting to the enable with no edge. Their stimulus changes controls just after a falling edge and samples the outputs before the next rising edge, so no edge can explain a change. The feedback divider is built in the bench by routing `term_n` back into `sload_n`. The bench then measures the spacing of the low pulses over several periods, which also covers the cycle at zero.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  // operation chosen for the next rising edge
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2
  } op_e;
endpackage

// File: rtl/pdc_next_state.sv
module pdc_next_state
  import pdc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] jam,
  input  logic             sload_n,
  input  logic             cnt_en_n,
  output logic [WIDTH-1:0] nxt,
  output logic             upd
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  op_e op;

  // synchronous load outranks counting
  always_comb begin
    if (!sload_n)       op = OP_LOAD;
    else if (!cnt_en_n) op = OP_STEP;
    else                op = OP_HOLD;
  end

  always_comb begin
    nxt = cur;
    upd = 1'b0;
    case (op)
      OP_LOAD: begin
        nxt = jam;
        upd = 1'b1;
      end
      OP_STEP: begin
        nxt = cur - ONE;   // modular: zero wraps to all ones
        upd = 1'b1;
      end
      default: begin
        nxt = cur;
        upd = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pdc_count_reg.sv
module pdc_count_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_max_n,
  input  logic             aload_n,
  input  logic [WIDTH-1:0] jam,
  input  logic             upd,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);
  // clear beats asynchronous load; clock enable written out
  always_ff @(posedge clk or negedge clr_max_n or negedge aload_n) begin
    if (!clr_max_n)   q <= '1;
    else if (!aload_n) q <= jam;
    else if (upd)      q <= nxt;
  end
endmodule

// File: rtl/pdc_term_detect.sv
module pdc_term_detect #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] count,
  input  logic             cnt_en_n,
  output logic             term_n
);
  always_comb begin
    term_n = ~((count == '0) & ~cnt_en_n);
  end
endmodule

// File: rtl/preset_down_counter.sv
module preset_down_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_max_n,
  input  logic             aload_n,
  input  logic             sload_n,
  input  logic             cnt_en_n,
  input  logic [WIDTH-1:0] jam,
  output logic [WIDTH-1:0] count,
  output logic             term_n
);
  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] nxt;
  logic             upd;

  pdc_next_state #(.WIDTH(WIDTH)) u_next (
    .cur      (q),
    .jam      (jam),
    .sload_n  (sload_n),
    .cnt_en_n (cnt_en_n),
    .nxt      (nxt),
    .upd      (upd)
  );

  pdc_count_reg #(.WIDTH(WIDTH)) u_reg (
    .clk       (clk),
    .clr_max_n (clr_max_n),
    .aload_n   (aload_n),
    .jam       (jam),
    .upd       (upd),
    .nxt       (nxt),
    .q         (q)
  );

  // transparent view while the asynchronous controls are held
  always_comb begin
    if (!clr_max_n)    count = '1;
    else if (!aload_n) count = jam;
    else               count = q;
  end

  pdc_term_detect #(.WIDTH(WIDTH)) u_term (
    .count    (count),
    .cnt_en_n (cnt_en_n),
    .term_n   (term_n)
  );
endmodule

// File: rtl/pdc_checker.sv
module pdc_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             clr_max_n,
  input logic             aload_n,
  input logic             sload_n,
  input logic             cnt_en_n,
  input logic [WIDTH-1:0] jam,
  input logic [WIDTH-1:0] count,
  input logic             term_n
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always @(posedge clk) begin
    if (!clr_max_n) begin
      AST_CLEAR_FULL: assert (count == '1) else $error("clear not all ones"); // R1
    end
    if (clr_max_n && !aload_n) begin
      AST_ALOAD_FOLLOW: assert (count == jam) else $error("async load not transparent"); // R2
    end
  end

  AST_SLOAD_TAKE: assert property (@(posedge clk) disable iff (!clr_max_n || !aload_n)
    !sload_n |=> (count == $past(jam))); // R3

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!clr_max_n || !aload_n)
    (sload_n && !cnt_en_n) |=> (count == $past(count) - ONE)); // R4

  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!clr_max_n || !aload_n)
    (sload_n && cnt_en_n) |=> $stable(count)); // R5

  AST_TERM_ZERO: assert property (@(posedge clk) disable iff (!clr_max_n)
    !term_n |-> ((count == '0) && !cnt_en_n)); // R6

  AST_TERM_SHORT: assert property (@(posedge clk) disable iff (!clr_max_n || !aload_n)
    (!term_n && sload_n && !cnt_en_n) |=> term_n); // R6
endmodule

bind preset_down_counter pdc_checker #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .clr_max_n (clr_max_n),
  .aload_n   (aload_n),
  .sload_n   (sload_n),
  .cnt_en_n  (cnt_en_n),
  .jam       (jam),
  .count     (count),
  .term_n    (term_n)
);

// File: tb/test_preset_down_counter.sv
module test_preset_down_counter;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 8;

  logic             clk;
  logic             clr_max_n, aload_n, sload_tb_n, cnt_en_n, use_fb;
  logic [WIDTH-1:0] jam;
  logic [WIDTH-1:0] count;
  logic             term_n;
  logic             sload_w;
  int checks = 0;
  int fails  = 0;

  assign sload_w = use_fb ? term_n : sload_tb_n;

  preset_down_counter #(.WIDTH(WIDTH)) i_preset_down_counter (
    .clk       (clk),
    .clr_max_n (clr_max_n),
    .aload_n   (aload_n),
    .sload_n   (sload_w),
    .cnt_en_n  (cnt_en_n),
    .jam       (jam),
    .count     (count),
    .term_n    (term_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // advance past one rising edge, land just after the falling edge
  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic t_clear();
    clr_max_n = 1'b0; aload_n = 1'b0; sload_tb_n = 1'b0; cnt_en_n = 1'b1; jam = 8'h12;
    #2;
    chk("R1", "clear count", 32'(count), 32'hFF);
    chk("R10", "clear beats loads", 32'(count), 32'hFF);
    chk("R6", "term idle", 32'(term_n), 32'h1);
    tick();
    chk("R10", "clear beats sync load at edge", 32'(count), 32'hFF);
    aload_n = 1'b1; sload_tb_n = 1'b1;
    tick();
    clr_max_n = 1'b1;
    tick();
    chk("R5", "hold after clear", 32'(count), 32'hFF);
  endtask

  task automatic t_count_wrap();
    sload_tb_n = 1'b0; jam = 8'h05;
    tick();
    chk("R3", "sync load with enable high", 32'(count), 32'h05);
    sload_tb_n = 1'b1; cnt_en_n = 1'b0;
    for (int i = 4; i >= 0; i--) begin
      tick();
      chk("R4", "step down", 32'(count), 32'(i));
    end
    chk("R6", "term low at zero", 32'(term_n), 32'h0);
    cnt_en_n = 1'b1;
    #1;
    chk("R6", "term gated by enable", 32'(term_n), 32'h1);
    tick();
    tick();
    chk("R5", "hold at zero", 32'(count), 32'h00);
    cnt_en_n = 1'b0;
    #1;
    chk("R6", "term returns without clock", 32'(term_n), 32'h0);
    tick();
    chk("R7", "wrap to all ones", 32'(count), 32'hFF);
    chk("R6", "term one period", 32'(term_n), 32'h1);
  endtask

  task automatic t_sload_priority();
    sload_tb_n = 1'b0; jam = 8'h20;   // enable still low
    tick();
    chk("R3", "sync load beats counting", 32'(count), 32'h20);
    sload_tb_n = 1'b1; cnt_en_n = 1'b1;
    tick(); tick(); tick();
    chk("R5", "hold nonzero", 32'(count), 32'h20);
  endtask

  task automatic t_aload();
    aload_n = 1'b0; jam = 8'h5A;
    #1;
    chk("R2", "async load no clock", 32'(count), 32'h5A);
    jam = 8'h33;
    #1;
    chk("R2", "async load follows jam", 32'(count), 32'h33);
    cnt_en_n = 1'b0; sload_tb_n = 1'b0;
    tick();
    chk("R10", "async load beats sync load and count", 32'(count), 32'h33);
    aload_n = 1'b1; sload_tb_n = 1'b1; jam = 8'h99;
    #1;
    chk("R2", "value kept after release", 32'(count), 32'h33);
    tick();
    chk("R4", "count after async load", 32'(count), 32'h32);
  endtask

  task automatic t_clear_midcycle();
    clr_max_n = 1'b0;
    #1;
    chk("R1", "clear between edges", 32'(count), 32'hFF);
    aload_n = 1'b0; jam = 8'h44;
    #1;
    chk("R10", "clear beats async load", 32'(count), 32'hFF);
    aload_n = 1'b1;
    tick();
    clr_max_n = 1'b1;
    tick();
    chk("R4", "count from all ones", 32'(count), 32'hFE);
  endtask

  task automatic t_msb();
    sload_tb_n = 1'b0; jam = 8'h80;
    tick();
    chk("R9", "msb loaded", 32'(count[WIDTH-1]), 32'h1);
    sload_tb_n = 1'b1;
    tick();
    chk("R9", "0x80 minus one", 32'(count), 32'h7F);
  endtask

  task automatic t_divider();
    int last;
    int lows;
    int bad;
    last = -1; lows = 0; bad = 0;
    cnt_en_n = 1'b0; jam = 8'd3;
    aload_n = 1'b0;
    tick();
    use_fb = 1'b1;
    aload_n = 1'b1;
    for (int k = 1; k <= 16; k++) begin
      tick();
      if (!term_n) begin
        lows++;
        if (count != 8'h00) bad++;
        if (last >= 0 && (k - last) != 4) bad++;
        last = k;
      end
    end
    chk("R8", "pulses in 16 clocks", 32'(lows), 32'd4);
    chk("R8", "spacing N+1", 32'(bad), 32'd0);
    use_fb = 1'b0; sload_tb_n = 1'b1;
  endtask

  initial begin
    use_fb = 1'b0;
    t_clear();
    t_count_wrap();
    t_sload_priority();
    t_aload();
    t_clear_midcycle();
    t_msb();
    t_divider();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule